// File: doc/BRIEF.md
# Burst-capable processor bus cycle controller

This block sits between a 32-bit core-side request port and an external memory bus, and turns each request into one or more bus cycles. A request carries a byte address, a size (byte, half word or double word), a write flag and, for reads, a burst flag. Single cycles open with an active-low address strobe. They drive a word address and active-low byte enables, and they end when either the normal ready or the burst ready input is sampled low. An access that runs past a double-word boundary is split into two cycles, each with its own byte-enable mask. When the 8-bit bus-size input is sampled low at completion, the cycle is repeated until every enabled byte has been moved one at a time.

A burst read fetches a line of four double words. It opens with a single strobe at the line base address. Each further beat completed with burst ready takes one clock and changes only the low word-address bits. The burst-last output marks the data phase of the final beat. A beat completed with normal ready instead makes the controller open a fresh cycle for the next beat.

Two inputs release the bus. Back-off floats every output group from the next clock and aborts the cycle in flight. That cycle is then restarted from its address phase once back-off is sampled high. Address hold floats only the address group and leaves sequencing and the data bus alone. Tri-state is expressed through two output-enable signals.

Top module: `bbc_bus_ctrl`

## Requirements
- R1: While reset is held, req_ready is 1, bus_ads_n, bus_blast_n and all four bus_be_n bits are 1, addr_oe is 1, and data_oe, rsp_valid and rsp_done are 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 1 only when the controller is idle and bus_boff_n is high, and it returns to 1 in the same cycle that rsp_done pulses.
- R3: bus_ads_n is low for exactly one clock at the start of each bus cycle. The first such clock is the one after a request is taken.
- R4: A single cycle completes at the first rising edge after its strobe clock where bus_rdy_n or bus_brdy_n is low. Wait cycles are allowed. bus_blast_n is low throughout its data phase.
- R5: Byte enables are active low. bus_be_n bit i is 0 when byte lane i is covered by the access. The covered lanes run from address bits [1:0] upward for 1, 2 or 4 bytes, for req_size 0, 1 or 2.
- R6: An access whose bytes cross a double-word boundary takes two cycles. The first is at word address addr[31:2] and carries the lanes from the offset up. The second is at addr[31:2]+1 and carries the remaining low lanes. Read data returns with the byte at the request address in rsp_rdata[7:0], and bytes beyond the size are zero.
- R7: For writes, byte k of req_wdata leaves on the lane of address addr+k. bus_wr is 1, and data_oe is 1 during the address and data clocks of every write cycle and 0 otherwise.
- R8: A burst read (req_burst=1, req_write=0) issues word addresses base, base+1, base+2, base+3, where base is addr[31:2] with its two low bits cleared. All byte enables are 0. Each beat gives one rsp_valid pulse carrying bus_din, a beat completed with bus_brdy_n continues in the very next clock, and bus_blast_n is low only during the data phase of the fourth beat.
- R9: A burst beat completed with bus_rdy_n low opens a new bus cycle, with the strobe and the next beat address, in the following clock.
- R10: If bus_bs8_n is low at a completing edge, only the lowest still-enabled lane is retired. The cycle is repeated, with the byte enables showing only the lanes not yet moved, until none remain.
- R11: If bus_boff_n is low at a rising edge, then from the next clock addr_oe and data_oe are 0 and bus_ads_n and bus_blast_n are 1, and any ready sampled at that edge is ignored. After bus_boff_n is sampled high, the aborted cycle restarts with a strobe at the same address and byte enables.
- R12: In the clock after bus_ahold is sampled high, addr_oe is 0 while data_oe and the cycle sequencing continue unchanged.
- R13: rsp_done pulses for one clock after the final completion of a request. For a single read, rsp_valid pulses together with it. For a write, rsp_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | Line-fill burst (reads only) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 half word, 2 double word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_done | output | 1 | Request finished pulse |
| bus_addr | output | ADDR_W-2 | Word address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_blast_n | output | 1 | Active-low last-transfer flag |
| bus_wr | output | 1 | Write cycle in progress |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_rdy_n | input | 1 | Normal ready, active low |
| bus_brdy_n | input | 1 | Burst ready, active low |
| bus_boff_n | input | 1 | Back-off, active low |
| bus_ahold | input | 1 | Address hold, active high |
| bus_bs8_n | input | 1 | Byte-wide bus size, active low |
| addr_oe | output | 1 | Drive enable for address group |
| data_oe | output | 1 | Drive enable for data lanes |

## Verification
The properties assume that the bus side raises no ready before a strobe has been seen, and that the core never requests a burst write. They also assume that bus_bs8_n stays high for the whole of a burst, and that back-off and address hold are held low and high respectively only across whole clocks. The bench acts as a responder that drives ready or burst ready only in data-phase clocks, changes every input on the falling edge, and asserts the narrow-bus input only during single cycles. Its sweep covers every offset, every size, both directions and both bus widths. Back-off and address hold are applied in directed sequences at known phases of a cycle.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_BOFF = 2'd3
    } bus_st_e;

    // isolate the lowest set lane of a mask
    function automatic logic [LANES-1:0] lowest_lane(input logic [LANES-1:0] m);
        return m & (~m + 1'b1);
    endfunction
endpackage

// File: rtl/bbc_lane_plan.sv
module bbc_lane_plan
    import bbc_pkg::*;
(
    input  logic [1:0]       off_i,
    input  logic [1:0]       size_i,
    output logic [LANES-1:0] lo_mask_o,
    output logic [LANES-1:0] hi_mask_o,
    output logic             split_o
);
    logic [2*LANES-1:0] run;
    logic [2*LANES-1:0] span;

    always_comb begin
        unique case (size_i)
            2'd0:    run = (2*LANES)'(4'b0001);
            2'd1:    run = (2*LANES)'(4'b0011);
            default: run = (2*LANES)'(4'b1111);
        endcase
        span = run << off_i;
    end

    assign lo_mask_o = span[LANES-1:0];
    assign hi_mask_o = span[2*LANES-1:LANES];
    assign split_o   = |span[2*LANES-1:LANES];
endmodule

// File: rtl/bbc_rd_merge.sv
module bbc_rd_merge
    import bbc_pkg::*;
(
    input  logic [2*DW-1:0]  acc_i,
    input  logic [DW-1:0]    din_i,
    input  logic [LANES-1:0] take_i,
    input  logic             piece_i,
    input  logic [1:0]       off_i,
    output logic [2*DW-1:0]  acc_o,
    output logic [DW-1:0]    aligned_o
);
    for (genvar p = 0; p < 2; p++) begin : g_piece
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign acc_o[(p*LANES+l)*8 +: 8] =
                (take_i[l] && (piece_i == 1'(p))) ? din_i[l*8 +: 8]
                                                  : acc_i[(p*LANES+l)*8 +: 8];
        end
    end

    assign aligned_o = DW'(acc_o >> {off_i, 3'b000});
endmodule

// File: rtl/bbc_bus_ctrl.sv
module bbc_bus_ctrl
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-3:0] bus_addr,
    output logic [3:0]        bus_be_n,
    output logic              bus_ads_n,
    output logic              bus_blast_n,
    output logic              bus_wr,
    output logic [31:0]       bus_dout,
    input  logic [31:0]       bus_din,
    input  logic              bus_rdy_n,
    input  logic              bus_brdy_n,
    input  logic              bus_boff_n,
    input  logic              bus_ahold,
    input  logic              bus_bs8_n,
    output logic              addr_oe,
    output logic              data_oe
);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int WA_W   = ADDR_W - 2;

    typedef struct packed {
        bus_st_e          st;
        logic             wr;
        logic             burst;
        logic             split;
        logic             piece;
        logic [WA_W-1:0]  wa;
        logic [1:0]       off;
        logic [LANES-1:0] mask;
        logic [LANES-1:0] hi_mask;
        logic [BEAT_W-1:0] beat;
        logic [2*DW-1:0]  wbuf;
        logic [2*DW-1:0]  rbuf;
        logic [DW-1:0]    rdata;
        logic             rvalid;
        logic             done;
        logic             bo;
        logic             ah;
    } ctl_t;

    ctl_t q, n;

    logic [LANES-1:0] plan_lo, plan_hi, take, left;
    logic             plan_split, finish, new_burst, on_bus;
    logic [2*DW-1:0]  merged;
    logic [DW-1:0]    aligned;

    bbc_lane_plan u_plan (
        .off_i     (req_addr[1:0]),
        .size_i    (req_size),
        .lo_mask_o (plan_lo),
        .hi_mask_o (plan_hi),
        .split_o   (plan_split)
    );

    bbc_rd_merge u_merge (
        .acc_i     (q.rbuf),
        .din_i     (bus_din),
        .take_i    (take),
        .piece_i   (q.piece),
        .off_i     (q.off),
        .acc_o     (merged),
        .aligned_o (aligned)
    );

    assign req_ready = (q.st == ST_IDLE) && bus_boff_n;
    assign new_burst = req_burst && !req_write;
    assign take      = bus_bs8_n ? q.mask : lowest_lane(q.mask);
    assign left      = q.mask & ~take;
    assign finish    = !bus_rdy_n || !bus_brdy_n;

    always_comb begin
        n        = q;
        n.rvalid = 1'b0;
        n.done   = 1'b0;
        n.bo     = !bus_boff_n;
        n.ah     = bus_ahold;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    n.st      = ST_ADDR;
                    n.wr      = req_write;
                    n.burst   = new_burst;
                    n.off     = req_addr[1:0];
                    n.piece   = 1'b0;
                    n.beat    = '0;
                    n.rbuf    = '0;
                    n.split   = plan_split && !new_burst;
                    n.mask    = new_burst ? '1 : plan_lo;
                    n.hi_mask = plan_hi;
                    n.wa      = new_burst ? {req_addr[ADDR_W-1:2+BEAT_W], {BEAT_W{1'b0}}}
                                          : req_addr[ADDR_W-1:2];
                    n.wbuf    = {{DW{1'b0}}, req_wdata} << {req_addr[1:0], 3'b000};
                end
            end
            ST_ADDR: n.st = bus_boff_n ? ST_DATA : ST_BOFF;
            ST_DATA: begin
                if (!bus_boff_n) begin
                    n.st = ST_BOFF;
                end else if (finish) begin
                    if (q.burst) begin
                        n.rvalid = 1'b1;
                        n.rdata  = bus_din;
                        if (q.beat == BEAT_W'(BEATS - 1)) begin
                            n.done = 1'b1;
                            n.st   = ST_IDLE;
                        end else begin
                            n.beat = q.beat + 1'b1;
                            n.st   = bus_rdy_n ? ST_DATA : ST_ADDR;
                        end
                    end else begin
                        n.rbuf = merged;
                        if (left != '0) begin
                            n.mask = left;
                            n.st   = ST_ADDR;
                        end else if (q.split && !q.piece) begin
                            n.piece = 1'b1;
                            n.mask  = q.hi_mask;
                            n.st    = ST_ADDR;
                        end else begin
                            n.done   = 1'b1;
                            n.rvalid = !q.wr;
                            n.rdata  = aligned;
                            n.st     = ST_IDLE;
                        end
                    end
                end
            end
            ST_BOFF: if (bus_boff_n) n.st = ST_ADDR;
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign on_bus      = (q.st == ST_ADDR) || (q.st == ST_DATA);
    assign bus_ads_n   = !(q.st == ST_ADDR);
    assign bus_blast_n = !((q.st == ST_DATA) && (!q.burst || (q.beat == BEAT_W'(BEATS - 1))));
    assign bus_addr    = q.burst ? {q.wa[WA_W-1:BEAT_W], q.beat} : (q.wa + WA_W'(q.piece));
    assign bus_be_n    = on_bus ? ~q.mask : '1;
    assign bus_wr      = on_bus && q.wr;
    assign bus_dout    = q.piece ? q.wbuf[2*DW-1:DW] : q.wbuf[DW-1:0];
    assign addr_oe     = !q.bo && !q.ah;
    assign data_oe     = !q.bo && on_bus && q.wr;
    assign rsp_valid   = q.rvalid;
    assign rsp_rdata   = q.rdata;
    assign rsp_done    = q.done;
endmodule

// File: rtl/bbc_bus_ctrl_sva.sv
module bbc_bus_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ads_n,
    input logic       bus_blast_n,
    input logic [3:0] bus_be_n,
    input logic       bus_wr,
    input logic       bus_ahold,
    input logic       bus_boff_n,
    input logic       addr_oe,
    input logic       data_oe,
    input logic       rsp_valid,
    input logic       rsp_done
);
    assert_strobe_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    assert_strobe_has_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |-> (bus_be_n != 4'hF));

    assert_last_not_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_blast_n |-> bus_ads_n);

    assert_data_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> bus_wr);

    assert_backoff_floats_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bus_boff_n) && $past(rst_n)) |->
            (!addr_oe && !data_oe && bus_ads_n && bus_blast_n));

    assert_hold_floats_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_ahold) && $past(rst_n)) |-> !addr_oe);

    assert_done_one_clock_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_read_data_not_on_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_wr);
endmodule

bind bbc_bus_ctrl bbc_bus_ctrl_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ads_n   (bus_ads_n),
    .bus_blast_n (bus_blast_n),
    .bus_be_n    (bus_be_n),
    .bus_wr      (bus_wr),
    .bus_ahold   (bus_ahold),
    .bus_boff_n  (bus_boff_n),
    .addr_oe     (addr_oe),
    .data_oe     (data_oe),
    .rsp_valid   (rsp_valid),
    .rsp_done    (rsp_done)
);

// File: tb/tb_bbc_bus_ctrl.sv
module tb_bbc_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_valid, rsp_done;
    logic [31:0] rsp_rdata;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be_n;
    logic        bus_ads_n, bus_blast_n, bus_wr, addr_oe, data_oe;
    logic [31:0] bus_dout;
    logic [31:0] bus_din = '0;
    logic        bus_rdy_n = 1'b1, bus_brdy_n = 1'b1, bus_boff_n = 1'b1;
    logic        bus_ahold = 1'b0, bus_bs8_n = 1'b1;

    int nvec = 0;
    int nerr = 0;
    logic [7:0] mem [0:127];

    always #2 clk = ~clk;

    bbc_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_burst(req_burst), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_ads_n(bus_ads_n), .bus_blast_n(bus_blast_n), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n),
        .bus_brdy_n(bus_brdy_n), .bus_boff_n(bus_boff_n), .bus_ahold(bus_ahold),
        .bus_bs8_n(bus_bs8_n), .addr_oe(addr_oe), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reset_mem();
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    endtask

    function automatic logic [31:0] mem_word(input int w);
        return {mem[w*4+3], mem[w*4+2], mem[w*4+1], mem[w*4]};
    endfunction

    task automatic offer(input bit wr, input bit burst, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_burst = burst;
        req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    endtask

    task automatic run_single(input bit wr, input int sz, input int off, input bit bs8,
                              input int ws, input bit use_b);
        logic [31:0] addr, wd, expd;
        logic [7:0]  m8;
        logic [3:0]  rem, tk;
        logic [29:0] ew [8];
        logic [3:0]  em [8];
        logic [29:0] ow [8];
        logic [3:0]  om [8];
        logic [7:0]  ref_mem [0:127];
        int en, on, nb, guard, wcnt, wb;
        bit fin, phase;
        string tag;
        addr = 32'h40 + 32'(off);
        wd   = 32'hC3A5_1E00 + 32'(off * 16 + sz * 4 + 2 * int'(bs8) + int'(wr));
        nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        m8   = 8'((1 << nb) - 1) << off;
        en   = 0;
        for (int p = 0; p < 2; p++) begin
            rem = m8[p*4 +: 4];
            while (rem != 4'd0) begin
                ew[en] = addr[31:2] + 30'(p);
                em[en] = rem;
                en++;
                rem = bs8 ? (rem & (rem - 4'd1)) : 4'd0;
            end
        end
        tag = bs8 ? "R10" : ((m8[7:4] != 4'd0) ? "R6" : "R5");
        reset_mem();
        for (int i = 0; i < 128; i++) ref_mem[i] = mem[i];
        expd = '0;
        for (int k = 0; k < nb; k++) begin
            if (wr) ref_mem[int'(addr) + k] = wd[8*k +: 8];
            expd[8*k +: 8] = mem[int'(addr) + k];
        end
        bus_bs8_n = !bs8;
        offer(wr, 1'b0, addr, 2'(sz), wd);
        on = 0; fin = 0; guard = 0; phase = 0; wcnt = 0;
        while (!fin && guard < 60) begin
            guard++;
            bus_rdy_n = 1'b1; bus_brdy_n = 1'b1;
            if (rsp_done) begin
                fin = 1;
                chk(rsp_valid == !wr, "R13 read data pulse with done", 64'(rsp_valid), 64'(!wr));
                if (!wr) chk(rsp_rdata == expd, "R6 read data assembly", 64'(rsp_rdata), 64'(expd));
                chk(req_ready == 1'b1, "R2 ready with done", 64'(req_ready), 64'd1);
            end else if (!bus_ads_n) begin
                if (on < 8) begin
                    ow[on] = bus_addr;
                    om[on] = ~bus_be_n;
                end
                on++;
                phase = 1; wcnt = 0;
            end else if (phase) begin
                chk(bus_blast_n == 1'b0, "R4 last flag in single data phase", 64'(bus_blast_n), 64'd0);
                chk(data_oe == wr, "R7 data drive enable", 64'(data_oe), 64'(wr));
                if (wcnt < ws) begin
                    wcnt++;
                end else begin
                    if (use_b) bus_brdy_n = 1'b0; else bus_rdy_n = 1'b0;
                    wb = int'(ow[on-1]);
                    bus_din = mem_word(wb);
                    if (wr) begin
                        tk = bs8 ? (om[on-1] & (~om[on-1] + 4'd1)) : om[on-1];
                        for (int l = 0; l < 4; l++)
                            if (tk[l]) mem[wb*4+l] = bus_dout[8*l +: 8];
                    end
                    phase = 0;
                end
            end
            if (!fin) @(negedge clk);
        end
        bus_bs8_n = 1'b1;
        chk(fin, "R13 done reached", 64'(fin), 64'd1);
        chk(on == en, {tag, " cycle count"}, 64'(on), 64'(en));
        for (int i = 0; i < en && i < on; i++) begin
            chk(ow[i] == ew[i], {tag, " cycle word address"}, 64'(ow[i]), 64'(ew[i]));
            chk(om[i] == em[i], {tag, " cycle byte enables"}, 64'(om[i]), 64'(em[i]));
        end
        if (wr)
            for (int i = 60; i < 76; i++)
                chk(mem[i] == ref_mem[i], "R7 written lanes", 64'(mem[i]), 64'(ref_mem[i]));
    endtask

    task automatic run_burst(input logic [31:0] a, input logic [3:0] use_rdy);
        logic [29:0] base;
        logic [31:0] pat;
        base = a[31:2] & ~30'd3;
        offer(1'b0, 1'b1, a, 2'd0, 32'd0);
        chk(bus_ads_n == 1'b0, "R3 strobe after accept", 64'(bus_ads_n), 64'd0);
        chk(bus_addr == base, "R8 burst base address", 64'(bus_addr), 64'(base));
        chk(bus_be_n == 4'h0, "R8 burst byte enables", 64'(bus_be_n), 64'd0);
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            chk(bus_ads_n == 1'b1, "R3 strobe single clock", 64'(bus_ads_n), 64'd1);
            chk(bus_addr == base + 30'(b), "R8 beat address", 64'(bus_addr), 64'(base + 30'(b)));
            chk(bus_blast_n == (b != 3), "R8 last flag", 64'(bus_blast_n), 64'(b != 3));
            pat = 32'hB000_0000 + 32'(b) * 32'h0101_1111 + a;
            bus_din = pat;
            if (use_rdy[b]) bus_rdy_n = 1'b0; else bus_brdy_n = 1'b0;
            @(negedge clk);
            bus_rdy_n = 1'b1; bus_brdy_n = 1'b1;
            chk(rsp_valid == 1'b1, "R8 beat data pulse", 64'(rsp_valid), 64'd1);
            chk(rsp_rdata == pat, "R8 beat data", 64'(rsp_rdata), 64'(pat));
            if (b == 3) begin
                chk(rsp_done == 1'b1, "R13 burst done", 64'(rsp_done), 64'd1);
            end else if (use_rdy[b]) begin
                chk(bus_ads_n == 1'b0, "R9 new strobe after normal ready", 64'(bus_ads_n), 64'd0);
                chk(bus_addr == base + 30'(b + 1), "R9 restart address", 64'(bus_addr), 64'(base + 30'(b + 1)));
                @(negedge clk);
            end else begin
                chk(bus_ads_n == 1'b1, "R8 burst continues without strobe", 64'(bus_ads_n), 64'd1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        reset_mem();
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        chk(bus_ads_n && bus_blast_n, "R1 strobes idle", 64'({bus_ads_n, bus_blast_n}), 64'd3);
        chk(bus_be_n == 4'hF, "R1 enables idle", 64'(bus_be_n), 64'hF);
        chk(addr_oe == 1'b1 && data_oe == 1'b0, "R1 drive enables", 64'({addr_oe, data_oe}), 64'd2);
        chk(!rsp_valid && !rsp_done, "R1 no response", 64'({rsp_valid, rsp_done}), 64'd0);
        rst_n = 1'b1;

        for (int wr = 0; wr < 2; wr++)
            for (int bs = 0; bs < 2; bs++)
                for (int sz = 0; sz < 3; sz++)
                    for (int off = 0; off < 4; off++)
                        run_single(wr[0], sz, off, bs[0], (off + sz) % 2, wr[0] ^ off[0]);

        run_burst(32'h0000_004C, 4'b0000);
        run_burst(32'h0000_0087, 4'b0101);
        run_burst(32'h0000_0030, 4'b1111);

        // R11: back-off in the address clock, ready during back-off ignored
        offer(1'b0, 1'b0, 32'h44, 2'd2, 32'd0);
        bus_boff_n = 1'b0;
        @(negedge clk);
        chk(!addr_oe && !data_oe, "R11 buses floated", 64'({addr_oe, data_oe}), 64'd0);
        chk(bus_ads_n && bus_blast_n, "R11 control released", 64'({bus_ads_n, bus_blast_n}), 64'd3);
        bus_rdy_n = 1'b0; bus_din = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11 ready ignored in back-off", 64'(rsp_done), 64'd0);
        chk(addr_oe == 1'b0, "R11 still floated", 64'(addr_oe), 64'd0);
        bus_boff_n = 1'b1; bus_rdy_n = 1'b1;
        @(negedge clk);
        chk(bus_ads_n == 1'b0 && addr_oe, "R11 restart strobe", 64'({bus_ads_n, addr_oe}), 64'd1);
        chk(bus_addr == 30'h11, "R11 restart address", 64'(bus_addr), 64'h11);
        @(negedge clk);
        bus_rdy_n = 1'b0; bus_din = 32'h1234_5678;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk(rsp_done && rsp_valid, "R11 restarted read done", 64'({rsp_done, rsp_valid}), 64'd3);
        chk(rsp_rdata == 32'h1234_5678, "R11 restarted read data", 64'(rsp_rdata), 64'h1234_5678);

        // R11: back-off in the data clock, coinciding with ready
        offer(1'b1, 1'b0, 32'h48, 2'd2, 32'h5566_7788);
        @(negedge clk);
        bus_boff_n = 1'b0; bus_rdy_n = 1'b0;
        @(negedge clk);
        chk(rsp_done == 1'b0 && data_oe == 1'b0, "R11 aborted write", 64'({rsp_done, data_oe}), 64'd0);
        bus_boff_n = 1'b1; bus_rdy_n = 1'b1;
        @(negedge clk);
        chk(bus_ads_n == 1'b0 && bus_addr == 30'h12, "R11 write restart", 64'({bus_ads_n, bus_addr}), 64'h12);
        chk(bus_be_n == 4'h0, "R11 restart enables", 64'(bus_be_n), 64'd0);
        @(negedge clk);
        chk(data_oe && bus_dout == 32'h5566_7788, "R7 restarted write data", 64'(bus_dout), 64'h5566_7788);
        bus_rdy_n = 1'b0;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk(rsp_done && !rsp_valid, "R13 write done", 64'({rsp_done, rsp_valid}), 64'd2);

        // R11/R2: back-off while idle holds off requests
        bus_boff_n = 1'b0;
        #0;
        chk(req_ready == 1'b0, "R2 not ready under back-off", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(addr_oe == 1'b0, "R11 idle float", 64'(addr_oe), 64'd0);
        bus_boff_n = 1'b1;

        // R12: address hold during a write
        offer(1'b1, 1'b0, 32'h4C, 2'd1, 32'h0000_ABCD);
        chk(bus_be_n == 4'hC, "R5 half-word enables", 64'(bus_be_n), 64'hC);
        bus_ahold = 1'b1;
        chk(addr_oe == 1'b1, "R12 not yet sampled", 64'(addr_oe), 64'd1);
        @(negedge clk);
        chk(!addr_oe && data_oe, "R12 address floated only", 64'({addr_oe, data_oe}), 64'd1);
        chk(bus_blast_n == 1'b0, "R12 sequencing continues", 64'(bus_blast_n), 64'd0);
        bus_rdy_n = 1'b0;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk(rsp_done && !addr_oe, "R12 done under hold", 64'({rsp_done, addr_oe}), 64'd2);
        bus_ahold = 1'b0;
        @(negedge clk);
        chk(addr_oe == 1'b1, "R12 address driven again", 64'(addr_oe), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule